// File: doc/BRIEF.md
# Channel-1 Fill Threshold Configuration Unit

This block is the byte-wide configuration front end for the channel-1 partially-full indication of a two-channel video FIFO. A host writes an 18-bit fill threshold in three byte-sized pieces. The pieces collect in staging registers and have no effect on the flag until the host writes zero to a separate commit register. That write moves the whole staged threshold into the active copy in one step, so the flag never sees a half-updated value.

The block takes the channel-1 fill count and the device operating mode, and drives the channel-1 partially-full flag. The active threshold is honoured only in dual-channel mode. In every other mode the flag is held low. The host interface is a plain write strobe with address and data, plus a combinational read port. Nothing streams through the block, so it has no valid/ready handshake and applies no back-pressure.

Top module: `fifo_thr_cfg`

## Requirements
- R1: After reset, every staging register reads 0x00 and the active threshold is floor(DEPTH*79/80), which is 258867 for the default DEPTH of 262144.
- R2: Writes set the staged threshold as follows: address 0x16 bits [1:0] hold threshold bits [17:16], address 0x17 holds bits [15:8], and address 0x18 holds bits [7:0]. Each register reads back at its own address.
- R3: Bits [7:2] of address 0x16 always read as zero, whatever value was written.
- R4: A write to a staging register leaves the flag unchanged until a commit happens.
- R5: Writing 0x00 to address 0x3F copies the full staged threshold into the active threshold at that clock edge.
- R6: Writing any nonzero value to address 0x3F is ignored, and the active threshold keeps its value.
- R7: In dual-channel mode (mode = 2'b01), the flag is high exactly when the fill count is greater than or equal to the active threshold. The flag follows the fill count combinationally.
- R8: In single-channel mode (2'b00), in cascade mode (2'b10) and with the unused code 2'b11, the flag is low whatever the fill count.
- R9: Reads of address 0x3F and of any unmapped address return 0x00.
- R10: Writes to unmapped addresses change neither the staged nor the active threshold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe; `wr_addr` and `wr_data` are sampled on the clock edge while it is high |
| wr_addr | input | 6 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 6 | Read address |
| rd_data | output | 8 | Combinational read data |
| mode | input | 2 | Operating mode: 00 single-channel, 01 dual-channel, 10 cascade |
| fill_cnt | input | 19 | Channel-1 fill count |
| pf_flag | output | 1 | Channel-1 partially-full flag |

## Verification
The bench writes a threshold that differs from the reset default and checks the flag at the old boundary before the commit. A design that applied staged writes at once would move the flag too early. It then writes a nonzero value to the commit address, which a design decoding only the address would wrongly treat as a commit. Threshold equality is probed at fill = T and fill = T-1, including a threshold of zero, so that an off-by-one in the compare or a strict greater-than shows up. Reserved bits, unmapped reads and writes, and all non-dual mode codes are checked at the ports, to catch a design that stores reserved bits, aliases addresses or forgets one of the mode codes.

// File: rtl/thr_cfg_pkg.sv
package thr_cfg_pkg;
  localparam int unsigned AW = 6;
  localparam int unsigned DW = 8;
  localparam int unsigned THR_W = 18;

  localparam logic [AW-1:0] A_THR_HI  = 6'h16;
  localparam logic [AW-1:0] A_THR_MID = 6'h17;
  localparam logic [AW-1:0] A_THR_LO  = 6'h18;
  localparam logic [AW-1:0] A_COMMIT  = 6'h3F;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_DUAL   = 2'b01,
    MODE_CASC   = 2'b10,
    MODE_RSVD   = 2'b11
  } op_mode_e;
endpackage

// File: rtl/thr_stage_regs.sv
module thr_stage_regs
  import thr_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data,
  output logic [THR_W-1:0] staged
);
  localparam int unsigned HI_W = THR_W - 2*DW;

  logic [HI_W-1:0] hi_q;
  logic [DW-1:0]   mid_q, lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      mid_q <= '0;
      lo_q  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_THR_HI:  hi_q  <= wr_data[HI_W-1:0];
        A_THR_MID: mid_q <= wr_data;
        A_THR_LO:  lo_q  <= wr_data;
        default: ;
      endcase
    end
  end

  assign staged = {hi_q, mid_q, lo_q};

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_THR_HI:  rd_data = {{(DW-HI_W){1'b0}}, hi_q};
      A_THR_MID: rd_data = mid_q;
      A_THR_LO:  rd_data = lo_q;
      default:   rd_data = '0;
    endcase
  end

  // R2: a write to the middle byte lands in the staged value
  p_mid_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_THR_MID) |=> staged[2*DW-1:DW] == $past(wr_data));
  // R3: reserved upper bits of the high register never read as one
  p_rsv_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == A_THR_HI) |-> rd_data[DW-1:HI_W] == '0);
endmodule

// File: rtl/thr_commit.sv
module thr_commit
  import thr_cfg_pkg::*;
#(
  parameter logic [THR_W-1:0] RST_THR = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [THR_W-1:0] staged,
  output logic [THR_W-1:0] active
);
  logic commit;
  assign commit = wr_en && (wr_addr == A_COMMIT) && (wr_data == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active <= RST_THR;
    else if (commit) active <= staged;
  end

  // R1: active threshold leaves reset at its default
  p_rst_default_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> active == RST_THR);
  // R5: a zero write to the commit address takes the staged value
  p_commit_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_COMMIT && wr_data == '0) |=> active == $past(staged));
  // R6: a nonzero write to the commit address changes nothing
  p_nz_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_COMMIT && wr_data != '0) |=> $stable(active));
  // R4 / R10: without a commit the active copy holds
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == A_COMMIT) |=> $stable(active));
endmodule

// File: rtl/pf_compare.sv
module pf_compare
  import thr_cfg_pkg::*;
#(
  parameter int unsigned FILL_W = 19
) (
  input  logic [FILL_W-1:0] fill_cnt,
  input  logic [THR_W-1:0]  thr,
  input  op_mode_e          mode,
  output logic              pf
);
  logic [FILL_W-1:0] thr_x;
  assign thr_x = FILL_W'(thr);
  assign pf = (mode == MODE_DUAL) && (fill_cnt >= thr_x);
endmodule

// File: rtl/fifo_thr_cfg.sv
module fifo_thr_cfg
  import thr_cfg_pkg::*;
#(
  parameter int unsigned DEPTH  = 262144,
  parameter int unsigned FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [5:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [5:0]        rd_addr,
  output logic [7:0]        rd_data,
  input  logic [1:0]        mode,
  input  logic [FILL_W-1:0] fill_cnt,
  output logic              pf_flag
);
  localparam logic [63:0] DEF_WIDE = (64'(DEPTH) * 64'd79) / 64'd80;
  localparam logic [THR_W-1:0] DEF_THR = DEF_WIDE[THR_W-1:0];

  logic [THR_W-1:0] staged, active;
  op_mode_e mode_e;
  assign mode_e = op_mode_e'(mode);

  thr_stage_regs u_stage (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .staged(staged)
  );

  thr_commit #(.RST_THR(DEF_THR)) u_commit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .staged(staged), .active(active)
  );

  pf_compare #(.FILL_W(FILL_W)) u_cmp (
    .fill_cnt(fill_cnt), .thr(active), .mode(mode_e), .pf(pf_flag)
  );

  // R8: outside dual-channel mode the flag stays low
  p_pf_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_DUAL) |-> !pf_flag);
  // R7: in dual-channel mode a full FIFO always raises the flag
  p_pf_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_DUAL && fill_cnt == FILL_W'(DEPTH)) |-> pf_flag);
endmodule

// File: tb/test_fifo_thr_cfg.sv
module test_fifo_thr_cfg;
  localparam int unsigned FW = 19;
  localparam int DEF = 258867;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [5:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic [1:0] mode = 2'b01;
  logic [FW-1:0] fill_cnt = '0;
  logic pf_flag;
  int errs = 0, checks = 0;

  always #2.5 clk = ~clk;

  fifo_thr_cfg i_fifo_thr_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .mode(mode), .fill_cnt(fill_cnt), .pf_flag(pf_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a, input int exp);
    rd_addr = a; #1;
    chk(req, int'(rd_data), exp);
  endtask

  task automatic pf_chk(input string req, input logic [1:0] m, input int f, input int exp);
    mode = m; fill_cnt = FW'(f); #1;
    chk(req, int'(pf_flag), exp);
  endtask

  task automatic t_reset;
    rd_chk("R1", 6'h16, 0); rd_chk("R1", 6'h17, 0); rd_chk("R1", 6'h18, 0);
    pf_chk("R1", 2'b01, DEF, 1);
    pf_chk("R1", 2'b01, DEF - 1, 0);
  endtask

  task automatic t_stage;
    wr(6'h16, 8'hFF); wr(6'h17, 8'h12); wr(6'h18, 8'h34);
    rd_chk("R3", 6'h16, 3);
    rd_chk("R2", 6'h17, 8'h12);
    rd_chk("R2", 6'h18, 8'h34);
    pf_chk("R4", 2'b01, 32'h31234, 0);
    pf_chk("R4", 2'b01, DEF, 1);
  endtask

  task automatic t_nonzero_commit;
    wr(6'h3F, 8'h01);
    pf_chk("R6", 2'b01, 32'h31234, 0);
    wr(6'h3F, 8'h80);
    pf_chk("R6", 2'b01, DEF - 1, 0);
  endtask

  task automatic t_commit;
    wr(6'h3F, 8'h00);
    pf_chk("R5", 2'b01, 32'h31234, 1);
    pf_chk("R7", 2'b01, 32'h31233, 0);
    pf_chk("R7", 2'b01, 262144, 1);
  endtask

  task automatic t_modes;
    pf_chk("R8", 2'b00, 262144, 0);
    pf_chk("R8", 2'b10, 262144, 0);
    pf_chk("R8", 2'b11, 262144, 0);
    pf_chk("R8", 2'b01, 262144, 1);
  endtask

  task automatic t_unmapped;
    rd_chk("R9", 6'h3F, 0);
    rd_chk("R9", 6'h20, 0);
    wr(6'h19, 8'hAA); wr(6'h15, 8'h55);
    rd_chk("R10", 6'h16, 3);
    rd_chk("R10", 6'h17, 8'h12);
    rd_chk("R10", 6'h18, 8'h34);
    pf_chk("R10", 2'b01, 32'h31233, 0);
  endtask

  task automatic t_zero_thr;
    wr(6'h16, 8'h00); wr(6'h17, 8'h00); wr(6'h18, 8'h00);
    pf_chk("R4", 2'b01, 0, 0);
    wr(6'h3F, 8'h00);
    pf_chk("R7", 2'b01, 0, 1);
    pf_chk("R8", 2'b00, 0, 0);
  endtask

  initial begin
    #2000000;
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_stage;
    t_nonzero_commit;
    t_commit;
    t_modes;
    t_unmapped;
    t_zero_thr;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule